// File: doc/BRIEF.md
# Serial Audio Byte Receiver

This block receives a serial audio stream on three asynchronous wires (a bit clock, a data line and an active-low chip select) and turns it into bytes on a parallel output in the system clock domain. Each finished byte appears on `data_o` together with a one-cycle `valid_o` pulse. All serial inputs pass through a two-flop synchronizer before use. The block finds data-clock edges by comparing successive synchronized samples.

Four mode inputs control reception. `fall_edge_i` picks the data-clock edge that captures each bit. `lsb_first_i` picks whether the first bit on the wire lands in bit 0 or bit 7 of the byte. `share_i` and `native_i` together let the receiver run from the command bus select instead of its own: with both set, the receiver takes bits only while `ccs_ni` is high, which leaves the command side free to assert it. The block copies the mode inputs into an internal register only at byte boundaries, so no byte is ever built with mixed settings. After reset that register holds native mode on and every other mode off.

Top module: `sdi_rx`

## Requirements
- R1: While and after reset, before any byte completes, `valid_o` is 0 and `data_o` is 0.
- R2: With `fall_edge_i` = 0, each bit is the value of `sdata_i` at a rising edge of `sclk_i`.
- R3: With `fall_edge_i` = 1, each bit is the value of `sdata_i` at a falling edge of `sclk_i`.
- R4: With `lsb_first_i` = 0, the first bit received becomes `data_o[7]` and the eighth becomes `data_o[0]`.
- R5: With `lsb_first_i` = 1, the first bit received becomes `data_o[0]` and the eighth becomes `data_o[7]`.
- R6: With `share_i` = 1 and `native_i` = 1, bits are accepted only while `ccs_ni` is high, and `dcs_ni` has no effect.
- R7: With `share_i` = 1 and `native_i` = 0, the receiver uses its own select: bits are accepted only while `dcs_ni` is low, and `ccs_ni` has no effect.
- R8: When the select in use goes inactive, any partial byte is discarded and produces no output. The next byte starts from its first bit.
- R9: `valid_o` is high for exactly one system cycle per byte. `data_o` holds the last byte until the next byte completes.
- R10: `valid_o` rises on the third rising edge of `clk_i` after the sampling edge of the eighth bit appears on `sclk_i`.
- R11: A change to a mode input made partway through a byte does not affect that byte. It takes effect from the next byte.
- R12: Bytes sent back to back under one continuous select are each delivered, with no gap needed between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial data clock, asynchronous |
| sdata_i | input | 1 | Serial data line |
| dcs_ni | input | 1 | Data port select, active low |
| ccs_ni | input | 1 | Command bus select, active low |
| fall_edge_i | input | 1 | 0: sample on rising edge, 1: sample on falling edge |
| lsb_first_i | input | 1 | 0: MSB first, 1: LSB first |
| share_i | input | 1 | Request a select shared with the command bus |
| native_i | input | 1 | Native mode; needed together with share_i for sharing |
| data_o | output | DW | Last assembled byte |
| valid_o | output | 1 | One-cycle strobe when a byte completes |

## Verification
A byte is due three system cycles after its final sampling edge: two cycles go to the synchronizer and one to the register stage that follows edge detection. The bench drives every serial input on the falling edge of `clk_i` and timestamps both that drive and the observed `valid_o` with one shared cycle counter, so the latency check compares against exactly 3. Value checks run at least two cycles after a byte's last data-clock phase, well past that point. The line sets a different value before each edge, so the same sweep also shows which edge did the sampling. Ignored-select cases are checked by counting output strobes over the whole stimulus window.

// File: rtl/sdi_rx_pkg.sv
package sdi_rx_pkg;
  typedef struct packed {
    logic share;
    logic native;
    logic lsb_first;
    logic fall_edge;
  } mode_t;

  localparam mode_t MODE_RST = '{share: 1'b0, native: 1'b1, lsb_first: 1'b0, fall_edge: 1'b0};
endpackage

// File: rtl/sdi_rx_sync.sv
module sdi_rx_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= RST_VAL;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/sdi_rx_edge.sv
module sdi_rx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_s_i,
  input  logic fall_edge_i,
  input  logic sel_act_i,
  output logic bit_stb_o
);
  logic sclk_d_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d_q <= 1'b0;
    else         sclk_d_q <= sclk_s_i;
  end

  assign rise      = sclk_s_i & ~sclk_d_q;
  assign fall      = ~sclk_s_i & sclk_d_q;
  assign bit_stb_o = sel_act_i & (fall_edge_i ? fall : rise);
endmodule

// File: rtl/sdi_rx_asm.sv
module sdi_rx_asm
  import sdi_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_stb_i,
  input  logic          bit_i,
  input  logic          sel_act_i,
  input  mode_t         mode_i,
  output mode_t         mode_o,
  output logic          cnt_zero_o,
  output logic [DW-1:0] data_o,
  output logic          valid_o
);
  localparam int            CW   = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [CW-1:0] cnt_q;
  logic [DW-1:0] sh_q, sh_nx, data_q;
  logic          valid_q;
  mode_t         mode_q;

  // shift direction picked by the mode latched for this byte
  assign sh_nx = mode_q.lsb_first ? {bit_i, sh_q[DW-1:1]} : {sh_q[DW-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sh_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      mode_q  <= MODE_RST;
    end else begin
      valid_q <= 1'b0;
      if (!sel_act_i) begin
        cnt_q <= '0;
      end else if (bit_stb_i) begin
        sh_q <= sh_nx;
        if (cnt_q == LAST) begin
          cnt_q   <= '0;
          data_q  <= sh_nx;
          valid_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      // modes only move between bytes
      if (cnt_q == '0 && !bit_stb_i) mode_q <= mode_i;
    end
  end

  assign mode_o     = mode_q;
  assign cnt_zero_o = (cnt_q == '0);
  assign data_o     = data_q;
  assign valid_o    = valid_q;
endmodule

// File: rtl/sdi_rx.sv
module sdi_rx
  import sdi_rx_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          sdata_i,
  input  logic          dcs_ni,
  input  logic          ccs_ni,
  input  logic          fall_edge_i,
  input  logic          lsb_first_i,
  input  logic          share_i,
  input  logic          native_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o
);
  logic  sclk_s, sdata_s, dcs_s, ccs_s;
  logic  sel_act, bit_stb, cnt_zero, shared;
  mode_t mode_in, mode_q;

  sdi_rx_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0011)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sclk_i, sdata_i, dcs_ni, ccs_ni}),
    .q_o    ({sclk_s, sdata_s, dcs_s, ccs_s})
  );

  assign mode_in = '{share: share_i, native: native_i, lsb_first: lsb_first_i, fall_edge: fall_edge_i};
  assign shared  = mode_q.share & mode_q.native;
  // shared: listen while the command select is idle
  assign sel_act = shared ? ccs_s : ~dcs_s;

  sdi_rx_edge u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_s_i    (sclk_s),
    .fall_edge_i (mode_q.fall_edge),
    .sel_act_i   (sel_act),
    .bit_stb_o   (bit_stb)
  );

  sdi_rx_asm #(.DW(DW)) u_asm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_stb_i  (bit_stb),
    .bit_i      (sdata_s),
    .sel_act_i  (sel_act),
    .mode_i     (mode_in),
    .mode_o     (mode_q),
    .cnt_zero_o (cnt_zero),
    .data_o     (data_o),
    .valid_o    (valid_o)
  );
endmodule

// File: rtl/sdi_rx_chk.sv
module sdi_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_o,
  input logic       bit_stb,
  input logic       sel_act,
  input logic       shared,
  input logic       ccs_s,
  input logic       cnt_zero,
  input logic [3:0] mode_bits
);
  // R9
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R10
  valid_after_stb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(bit_stb));

  // R8
  deselect_no_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_act |=> !valid_o);

  // R6
  shared_cmd_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shared && !ccs_s) |-> !bit_stb);

  // R11
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_zero |=> $stable(mode_bits));
endmodule

bind sdi_rx sdi_rx_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_o   (valid_o),
  .bit_stb   (bit_stb),
  .sel_act   (sel_act),
  .shared    (shared),
  .ccs_s     (ccs_s),
  .cnt_zero  (cnt_zero),
  .mode_bits (mode_q)
);

// File: tb/sdi_rx_bench.sv
module sdi_rx_bench;
  localparam int H = 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sclk_i = 1'b0, sdata_i = 1'b0, dcs_ni = 1'b1, ccs_ni = 1'b1;
  logic       fall_edge_i = 1'b0, lsb_first_i = 1'b0, share_i = 1'b0, native_i = 1'b1;
  logic [7:0] data_o;
  logic       valid_o;

  int checks = 0, fails = 0, cyc = 0;
  int rx_n = 0, rx_cyc = 0, t_edge = 0, multi = 0;
  logic [7:0] rx_val = '0;
  logic       valid_prev = 1'b0;
  bit         done = 1'b0;

  sdi_rx u_sdi_rx (.*);

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) begin
    if (valid_o) begin
      rx_val = data_o;
      rx_cyc = cyc;
      rx_n++;
      if (valid_prev) multi++;
    end
    valid_prev = valid_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // br: line value at rising edges, bf: at falling edges, wire order by lsb
  task automatic send_bits(input [7:0] br, input [7:0] bf, input int from, input int to,
                           input bit lsb, input bit fall);
    for (int i = from; i < to; i++) begin
      int idx = lsb ? i : 7 - i;
      sdata_i = br[idx];
      w(H);
      sclk_i = 1'b1;
      if (!fall) t_edge = cyc;
      w(H);
      sdata_i = bf[idx];
      w(H);
      sclk_i = 1'b0;
      if (fall) t_edge = cyc;
      w(H);
    end
  endtask

  task automatic send(input [7:0] br, input [7:0] bf, input bit lsb, input bit fall);
    send_bits(br, bf, 0, 8, lsb, fall);
  endtask

  initial begin
    int n0;
    w(5);
    chk(valid_o == 1'b0 && data_o == 8'h00, "R1 reset", {data_o, 3'b0, valid_o}, 0);
    rst_ni = 1'b1;
    w(4);
    chk(valid_o == 1'b0 && data_o == 8'h00, "R1 after reset", {data_o, 3'b0, valid_o}, 0);

    // sweep every byte under all four edge/order combinations
    for (int m = 0; m < 4; m++) begin
      bit f = m[0];
      bit l = m[1];
      string tag = {f ? "R3" : "R2", "/", l ? "R5" : "R4"};
      int base;
      fall_edge_i = f;
      lsb_first_i = l;
      w(4);
      dcs_ni = 1'b0;
      w(4);
      base = rx_n;
      for (int b = 0; b < 256; b++) begin
        logic [7:0] br = 8'(b);
        logic [7:0] bf = ~8'(b);
        n0 = rx_n;
        send(br, bf, l, f);
        w(2);
        chk(rx_n == n0 + 1, {tag, " count"}, rx_n - n0, 1);
        chk(rx_val == (f ? bf : br), tag, rx_val, f ? bf : br);
        if (b == 8'h5A) chk(rx_cyc - t_edge == 3, "R10 latency", rx_cyc - t_edge, 3);
      end
      chk(rx_n - base == 256, "R12 back-to-back", rx_n - base, 256);
      dcs_ni = 1'b1;
      w(6);
    end

    // R9: output held, single pulses
    w(10);
    chk(data_o == 8'h00, "R9 hold", data_o, 8'h00);
    chk(multi == 0, "R9 pulse width", multi, 0);

    fall_edge_i = 1'b0;
    lsb_first_i = 1'b0;
    w(4);

    // R8: partial byte dropped on deselect
    dcs_ni = 1'b0;
    w(4);
    n0 = rx_n;
    send_bits(8'hFF, 8'hFF, 0, 5, 1'b0, 1'b0);
    dcs_ni = 1'b1;
    w(6);
    chk(rx_n == n0, "R8 partial dropped", rx_n - n0, 0);
    dcs_ni = 1'b0;
    w(4);
    send(8'hC3, 8'h00, 1'b0, 1'b0);
    w(2);
    chk(rx_n == n0 + 1 && rx_val == 8'hC3, "R8 restart", rx_val, 8'hC3);

    // R11: order change mid-byte applies from next byte
    n0 = rx_n;
    send_bits(8'h96, 8'h00, 0, 3, 1'b0, 1'b0);
    lsb_first_i = 1'b1;
    send_bits(8'h96, 8'h00, 3, 8, 1'b0, 1'b0);
    w(2);
    chk(rx_val == 8'h96, "R11 old mode kept", rx_val, 8'h96);
    send(8'h2D, 8'h00, 1'b1, 1'b0);
    w(2);
    chk(rx_n == n0 + 2 && rx_val == 8'h2D, "R11 new mode", rx_val, 8'h2D);
    dcs_ni = 1'b1;
    lsb_first_i = 1'b0;
    w(6);

    // R6: shared select
    share_i = 1'b1;
    native_i = 1'b1;
    ccs_ni = 1'b0;
    w(6);
    n0 = rx_n;
    send(8'h33, 8'h00, 1'b0, 1'b0);
    w(4);
    chk(rx_n == n0, "R6 command busy", rx_n - n0, 0);
    ccs_ni = 1'b1;
    w(6);
    send(8'h71, 8'h00, 1'b0, 1'b0);
    w(2);
    chk(rx_n == n0 + 1 && rx_val == 8'h71, "R6 shared select", rx_val, 8'h71);
    dcs_ni = 1'b0;
    ccs_ni = 1'b0;
    w(6);
    n0 = rx_n;
    send(8'h44, 8'h00, 1'b0, 1'b0);
    w(4);
    chk(rx_n == n0, "R6 own select ignored", rx_n - n0, 0);
    dcs_ni = 1'b1;
    ccs_ni = 1'b1;
    w(6);

    // R7: share without native keeps own select
    native_i = 1'b0;
    w(6);
    n0 = rx_n;
    send(8'h55, 8'h00, 1'b0, 1'b0);
    w(4);
    chk(rx_n == n0, "R7 own select idle", rx_n - n0, 0);
    dcs_ni = 1'b0;
    ccs_ni = 1'b0;
    w(6);
    send(8'h18, 8'h00, 1'b0, 1'b0);
    w(2);
    chk(rx_n == n0 + 1 && rx_val == 8'h18, "R7 own select", rx_val, 8'h18);
    chk(multi == 0, "R9 pulse width final", multi, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule